// File: doc/BRIEF.md
# Serial Peripheral Slave with Buffered Transmit

This block is the target side of a four-wire synchronous serial link. It works in the phase mode where the leading edge of each bit cell launches data and the trailing edge captures it. A frame is eight bits, sent most significant bit first in both directions. The frame starts on the first serial clock edge after the select line goes low, not on the select line itself, so the master may keep select low across any number of back-to-back frames.

The parallel side writes transmit bytes into a holding register at any time. The shift register takes a copy of the holding register only on the edge that opens a frame, so a write made mid-frame waits for the next frame. If nothing new is written, the last byte is sent again. Each received byte appears on a parallel port together with a one-cycle valid pulse. The serial clock, select and data-in pins are synchronized into the system clock, which must run at least four times faster than the serial clock. The idle level of the serial clock is set by a polarity input.

The control core is a three-state machine. IDLE: select is high and MISO is not driven. ARMED: select is low and the core waits for a leading edge. SHIFT: a frame is in progress. The transitions are: IDLE to ARMED when select falls. ARMED to SHIFT on a leading edge, which loads the shift register. SHIFT to ARMED on the eighth trailing edge, which pulses valid. ARMED or SHIFT to IDLE when select rises, which drops any partial frame.

Top module: `spi_slave_buffered`

## Requirements
- R1: After reset, miso_oe is 0, miso is 0 and rx_valid is 0.
- R2: While ss_n is high, miso_oe is 0 and miso is 0. While ss_n is low, miso_oe is 1.
- R3: On the first leading edge after ss_n falls (or after a completed frame), miso takes bit 7 of the holding register.
- R4: Bits move MSB first. miso changes only on leading edges. mosi is captured on trailing edges, and the first captured bit lands in rx_data bit 7.
- R5: A single one-cycle rx_valid pulse follows the eighth trailing edge of each frame, with the complete byte on rx_data.
- R6: A tx_wr during a frame does not change the bits of that frame. The written byte is sent in the next frame.
- R7: If no tx_wr occurs between frames, the next frame sends the same byte again. The holding register resets to 0x00.
- R8: ss_n may stay low between frames. The next leading edge opens a new frame.
- R9: With cpol=0, sck idles low and the leading edge is rising. With cpol=1, sck idles high and the leading edge is falling.
- R10: If ss_n rises mid-frame, the partial frame is dropped with no rx_valid. The next frame starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level (0 low, 1 high) |
| sck | input | 1 | Serial clock from master |
| ss_n | input | 1 | Active-low select from master |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 when not driven |
| miso_oe | output | 1 | Output enable for the miso pad |
| tx_data | input | 8 | Byte to load into the holding register |
| tx_wr | input | 1 | Write strobe for tx_data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is complete |

## Verification
A bit counter that is out of step shows up as a misplaced or missing rx_valid pulse within the same frame. If the abort path is broken, the counter is not cleared, and the frame after an aborted one shows a shifted received byte or an extra pulse. A shift register that loads at the wrong moment produces a wrong bit on miso at the first sampling point after the fault. A mid-frame write that reaches the shifter corrupts the bits that remain in that frame. Running frames with both polarities, back to back and with writes in flight exposes each of these faults within one frame of the fault.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } spi_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-flop synchronizer with one extra stage for edge detection.
module spi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/spi_tx_holder.sv
// Transmit holding register; keeps the last written byte.
module spi_tx_holder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/spi_rx_shifter.sv
// Receive shift register, MSB enters first.
module spi_rx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/spi_slave_buffered.sv
module spi_slave_buffered
    import spi_slave_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpol,
    input  logic         sck,
    input  logic         ss_n,
    input  logic         mosi,
    output logic         miso,
    output logic         miso_oe,
    input  logic [W-1:0] tx_data,
    input  logic         tx_wr,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);
    localparam int          CNT_W   = $clog2(W);
    localparam int          NPINS   = 3;
    // Pin order: 0 = sck, 1 = ss_n, 2 = mosi; select resets inactive.
    localparam logic [2:0]  PIN_RST = 3'b010;

    logic [NPINS-1:0] pin_raw, pin_q, pin_rise, pin_fall;
    assign pin_raw = {mosi, ss_n, sck};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        spi_pin_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(PIN_RST[g])
        ) u_sync (
            .clk (clk),
            .rst_n(rst_n),
            .din (pin_raw[g]),
            .q   (pin_q[g]),
            .rise(pin_rise[g]),
            .fall(pin_fall[g])
        );
    end

    logic ss_s, mosi_s, lead, trail;
    assign ss_s   = pin_q[1];
    assign mosi_s = pin_q[2];
    assign lead   = cpol ? pin_fall[0] : pin_rise[0];
    assign trail  = cpol ? pin_rise[0] : pin_fall[0];

    logic [W-1:0] hold_q;
    spi_tx_holder #(.W(W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (tx_wr),
        .wdata(tx_data),
        .q    (hold_q)
    );

    spi_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     tx_sh;
    logic             last_bit, rx_shift_en;

    assign last_bit    = (bit_cnt == CNT_W'(W-1));
    assign rx_shift_en = (state_q == ST_SHIFT) && !ss_s && trail;

    spi_rx_shifter #(.W(W)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rx_shift_en),
        .din  (mosi_s),
        .q    (rx_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!ss_s) state_d = ST_ARMED;
            ST_ARMED: if (ss_s) state_d = ST_IDLE;
                      else if (lead) state_d = ST_SHIFT;
            ST_SHIFT: if (ss_s) state_d = ST_IDLE;
                      else if (trail && last_bit) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: bit_cnt <= '0;
                ST_ARMED: begin
                    if (!ss_s && lead) begin
                        tx_sh   <= hold_q;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (!ss_s) begin
                        if (lead && bit_cnt != '0)
                            tx_sh <= {tx_sh[W-2:0], 1'b0};
                        if (trail) begin
                            bit_cnt <= CNT_W'(bit_cnt + 1'b1);
                            if (last_bit) rx_valid <= 1'b1;
                        end
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    assign miso_oe = (state_q != ST_IDLE);
    assign miso    = miso_oe ? tx_sh[W-1] : 1'b0;
endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk
    import spi_slave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ss_s,
    input  logic       lead,
    input  logic       trail,
    input  logic       hold_msb,
    input  spi_state_e state_q,
    input  logic       miso,
    input  logic       miso_oe,
    input  logic       rx_valid
);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso);

    p_start_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ARMED && state_q == ST_SHIFT) |-> miso == $past(hold_msb));

    p_miso_lead_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && !$past(lead)) |-> $stable(miso));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_pulse_after_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(trail));

    p_abort_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !rx_valid);
endmodule

bind spi_slave_buffered spi_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ss_s    (ss_s),
    .lead    (lead),
    .trail   (trail),
    .hold_msb(hold_q[W-1]),
    .state_q (state_q),
    .miso    (miso),
    .miso_oe (miso_oe),
    .rx_valid(rx_valid)
);

// File: tb/sim_spi_slave_buffered.sv
`timescale 1ns/1ps
module sim_spi_slave_buffered;
    localparam int HALF = 8;   // system clocks per serial half-period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0;
    logic       sck = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe, rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 1'b0;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    spi_slave_buffered u0 (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .sck(sck), .ss_n(ss_n),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .tx_data(tx_data),
        .tx_wr(tx_wr), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected received bytes as rx_valid pulses appear.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected rx_valid", rx_data, 8'h00);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R5 rx byte", rx_data, e);
            end
        end
    end

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one frame, or a partial frame when nbits < 8.
    task automatic frame(input logic [7:0] out_b, input logic [7:0] exp_miso,
                         input string req, input int nbits,
                         input bit mid_wr, input logic [7:0] mid_val);
        logic [7:0] got;
        got = 8'h00;
        if (nbits == 8) exp_q.push_back(out_b);
        for (int i = 7; i >= 8 - nbits; i--) begin
            @(negedge clk);
            sck  = ~cpol;
            mosi = out_b[i];
            wait_clk(HALF);
            got[i] = miso;
            sck = cpol;
            if (mid_wr && i == 4) write_tx(mid_val);
            wait_clk(HALF);
        end
        if (nbits == 8) chk(got == exp_miso, req, got, exp_miso);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R1: reset state
        chk(miso_oe == 1'b0, "R1 miso_oe", {7'd0, miso_oe}, 8'h00);
        chk(miso == 1'b0, "R1 miso", {7'd0, miso}, 8'h00);
        chk(rx_valid == 1'b0, "R1 rx_valid", {7'd0, rx_valid}, 8'h00);
        rst_n = 1'b1;
        wait_clk(4);

        // R9 cpol=0, R3/R4 basic frame
        write_tx(8'hA5);
        ss_n = 1'b0;
        wait_clk(6);
        chk(miso_oe == 1'b1, "R2 oe while selected", {7'd0, miso_oe}, 8'h01);
        frame(8'h3C, 8'hA5, "R3 R4 R9 first frame", 8, 1'b0, 8'h00);
        // R8 back to back with select held, R7 repeat
        frame(8'hC3, 8'hA5, "R7 R8 repeat byte", 8, 1'b0, 8'h00);
        // R6 mid-frame write held
        write_tx(8'h5A);
        frame(8'h0F, 8'h5A, "R6 current frame unchanged", 8, 1'b1, 8'h81);
        frame(8'hF0, 8'h81, "R6 next frame takes write", 8, 1'b0, 8'h00);
        wait_clk(4);
        ss_n = 1'b1;
        wait_clk(6);
        chk(miso_oe == 1'b0, "R2 oe deselected", {7'd0, miso_oe}, 8'h00);
        chk(miso == 1'b0, "R2 miso deselected", {7'd0, miso}, 8'h00);

        // R10 abort mid-frame
        write_tx(8'h99);
        ss_n = 1'b0;
        wait_clk(6);
        frame(8'hFF, 8'h00, "R10 partial", 4, 1'b0, 8'h00);
        ss_n = 1'b1;
        wait_clk(8);
        ss_n = 1'b0;
        wait_clk(6);
        frame(8'h66, 8'h99, "R10 restart at bit 7", 8, 1'b0, 8'h00);
        ss_n = 1'b1;
        wait_clk(6);

        // R9 cpol=1
        cpol = 1'b1;
        sck  = 1'b1;
        wait_clk(8);
        write_tx(8'hE7);
        ss_n = 1'b0;
        wait_clk(6);
        frame(8'h18, 8'hE7, "R9 cpol1 frame", 8, 1'b0, 8'h00);
        frame(8'hFF, 8'hE7, "R7 R9 cpol1 repeat", 8, 1'b0, 8'h00);
        frame(8'h01, 8'hE7, "R4 lsb only", 8, 1'b0, 8'h00);
        wait_clk(6);
        ss_n = 1'b1;
        wait_clk(8);

        chk(exp_q.size() == 0, "R5 one pulse per frame", 8'(exp_q.size()), 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule